// File: doc/BRIEF.md
# Multi-Line Tagged Receive Silo

This block gathers characters from eight serial receiver lines into one shared first-in first-out store, the silo. Each receiver hands over a character with a one-cycle strobe, together with its framing and parity error indications. Every line has a one-character holding slot. A round-robin scanner moves at most one held character per clock into the silo. As it does so it tags the character with its line number and its error flags.

The host reads the buffer port and gets a self-describing 16-bit word. A bus read strobe removes that word from the silo. The host drains the silo by reading until the "present" bit comes back clear. A control word enables scanning, the receive interrupt, and an alarm mode. In alarm mode the interrupt is held back until a batch of characters has arrived since the last read.

Top module: `silo_rx_top`

## Requirements
- R1: The buffer word has bit 15 set when the silo holds an entry, line number in bits 10:8, character in bits 7:0, and bit 11 zero.
- R2: Bit 13 carries the framing error flag and bit 12 the parity error flag, both taken from the line inputs with the character's strobe.
- R3: The silo holds at most 64 entries. While it is full, nothing is stored and the waiting character stays in its line's holding slot.
- R4: A strobe on a line whose holding slot is still occupied and not being emptied that cycle drops the new character. The next character stored from that line has bit 14 (overrun) set, and later ones have it clear.
- R5: Control bit 5 is scan enable. While it is clear, strobes are ignored and nothing enters the silo.
- R6: Lines with a held character are served one per clock, in ascending order starting after the line served last, wrapping from 7 to 0. After reset the search starts at line 0.
- R7: With control bit 12 clear, the interrupt equals control bit 6 AND the silo being non-empty.
- R8: With control bit 12 set, the interrupt equals control bit 6 AND at least 16 entries stored since the last read that removed an entry.
- R9: A buffer read strobe removes exactly one entry. On an empty silo it returns zero and changes no state.
- R10: Entries are read back in the order they were stored.
- R11: After reset, the silo is empty, the control word is zero, the interrupt is low and the buffer word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 8 | Per-line character strobe |
| rx_char | input | 64 | Per-line character, line i in bits 8i+7:8i |
| rx_ferr | input | 8 | Per-line framing error with strobe |
| rx_perr | input | 8 | Per-line parity error with strobe |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: bit 5 scan, bit 6 interrupt enable, bit 12 alarm mode |
| buf_rd | input | 1 | Buffer read strobe, removes the head entry |
| buf_rdata | output | 16 | Head entry word, zero when empty |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench fills the silo to its limit and then loads one more character on a line. A design with an off-by-one in its full detection would store 65 entries, or lose the held character, when the silo is drained. The bench then strobes the same line once more while that character is still held. It checks that the dropped character never appears and that only the next character from that line carries the overrun flag; a sticky or misplaced flag would show up on the wrong word. Three lines strobe in the same cycle just after a middle line was served, which exposes a scanner that restarts at line 0 instead of rotating. In alarm mode the bench stops one entry short of the threshold and then reads once from a non-empty silo. A design that compares the fill level, or that does not restart its count on a read, raises the interrupt at the wrong time.

// File: rtl/silo_pkg.sv
package silo_pkg;
    localparam int WORD_W    = 16;
    localparam int CH_W      = 8;
    localparam int LINE_FW   = 3;
    localparam int CTL_SCAN  = 5;
    localparam int CTL_RXIE  = 6;
    localparam int CTL_ALARM = 12;

    typedef struct packed {
        logic               ovr;
        logic               ferr;
        logic               perr;
        logic [LINE_FW-1:0] line;
        logic [CH_W-1:0]    ch;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    function automatic logic [WORD_W-1:0] pack_word(entry_t e);
        return {1'b1, e.ovr, e.ferr, e.perr, 1'b0, e.line, e.ch};
    endfunction
endpackage

// File: rtl/silo_line_hold.sv
module silo_line_hold
    import silo_pkg::*;
#(
    parameter logic [LINE_FW-1:0] LINE_ID = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_en,
    input  logic            stb,
    input  logic [CH_W-1:0] ch,
    input  logic            ferr,
    input  logic            perr,
    input  logic            grant,
    output logic            pend,
    output entry_t          ent
);
    typedef struct packed {
        logic   v;
        logic   lost;
        entry_t e;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (grant) hold_d.v = 1'b0;
        if (scan_en && stb) begin
            if (hold_q.v && !grant) begin
                hold_d.lost = 1'b1;
            end else begin
                hold_d.v      = 1'b1;
                hold_d.e.ovr  = hold_q.lost;
                hold_d.e.ferr = ferr;
                hold_d.e.perr = perr;
                hold_d.e.line = LINE_ID;
                hold_d.e.ch   = ch;
                hold_d.lost   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign pend = hold_q.v;
    assign ent  = hold_q.e;

    // R6: the scanner only serves a line that holds a character
    p_grant_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> hold_q.v);

    // R4: a refused strobe leaves an overrun mark for the next character
    p_drop_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && stb && hold_q.v && !grant) |=> hold_q.lost);
endmodule

// File: rtl/silo_rr_pick.sv
module silo_rr_pick #(
    parameter int N = 8,
    localparam int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic          any,
    output logic [LW-1:0] idx
);
    typedef struct packed {
        logic [LW-1:0] last;
    } rr_t;

    rr_t rr_d, rr_q;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N; k >= 1; k--) begin
            automatic int c = (int'(rr_q.last) + k) % N;
            if (req[c]) begin
                any = 1'b1;
                idx = LW'(c);
            end
        end
    end

    always_comb begin
        rr_d = rr_q;
        if (advance) rr_d.last = idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rr_q.last <= LW'(N - 1);
        else        rr_q <= rr_d;
    end

    // R6: the picked line always has a request
    p_pick_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[idx]);
endmodule

// File: rtl/silo_fifo.sv
module silo_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 14,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (push) p_d.wp = bump(p_q.wp);
        if (pop)  p_d.rp = bump(p_q.rp);
        case ({push, pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[p_q.wp] <= din;
    end

    assign dout  = mem[p_q.rp];
    assign empty = (p_q.cnt == '0);
    assign full  = (int'(p_q.cnt) == DEPTH);
    assign level = p_q.cnt;

    // R3: nothing is written into a full silo
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R9: nothing is removed from an empty silo
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

    // R9: a read alone lowers the fill by exactly one
    p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (p_q.cnt == $past(p_q.cnt) - 1'b1));
endmodule

// File: rtl/silo_rx_top.sv
module silo_rx_top
    import silo_pkg::*;
#(
    parameter int NLINES    = 8,
    parameter int DEPTH     = 64,
    parameter int ALARM_LVL = 16,
    localparam int LW       = (NLINES > 1) ? $clog2(NLINES) : 1,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int AC_W     = $clog2(ALARM_LVL + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLINES-1:0]      rx_stb,
    input  logic [NLINES*CH_W-1:0] rx_char,
    input  logic [NLINES-1:0]      rx_ferr,
    input  logic [NLINES-1:0]      rx_perr,
    input  logic                   ctl_wr,
    input  logic [WORD_W-1:0]      ctl_wdata,
    input  logic                   buf_rd,
    output logic [WORD_W-1:0]      buf_rdata,
    output logic                   irq
);
    typedef struct packed {
        logic            scan;
        logic            rxie;
        logic            alarm;
        logic [AC_W-1:0] acnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NLINES-1:0] pend, grant;
    entry_t            ent [NLINES];
    logic              any, push, pop, empty, full;
    logic [LW-1:0]     pick;
    entry_t            head;
    logic [CW-1:0]     level;
    logic              unused_wbits;

    assign unused_wbits = ^ctl_wdata;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        silo_line_hold #(.LINE_ID(LINE_FW'(i))) i_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .scan_en (c_q.scan),
            .stb     (rx_stb[i]),
            .ch      (rx_char[i*CH_W +: CH_W]),
            .ferr    (rx_ferr[i]),
            .perr    (rx_perr[i]),
            .grant   (grant[i]),
            .pend    (pend[i]),
            .ent     (ent[i])
        );
        assign grant[i] = push && (int'(pick) == i);
    end

    silo_rr_pick #(.N(NLINES)) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pend),
        .advance (push),
        .any     (any),
        .idx     (pick)
    );

    assign push = c_q.scan && any && !full;
    assign pop  = buf_rd && !empty;

    silo_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) i_silo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (ent[pick]),
        .dout  (head),
        .empty (empty),
        .full  (full),
        .level (level)
    );

    always_comb begin
        c_d = c_q;
        if (ctl_wr) begin
            c_d.scan  = ctl_wdata[CTL_SCAN];
            c_d.rxie  = ctl_wdata[CTL_RXIE];
            c_d.alarm = ctl_wdata[CTL_ALARM];
        end
        if (pop)
            c_d.acnt = push ? AC_W'(1) : '0;
        else if (push && int'(c_q.acnt) < ALARM_LVL)
            c_d.acnt = c_q.acnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign buf_rdata = empty ? '0 : pack_word(head);
    assign irq = c_q.rxie && (c_q.alarm ? (int'(c_q.acnt) >= ALARM_LVL) : !empty);

    // R5: with scanning off the silo never grows
    p_scan_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.scan |=> (level <= $past(level)));

    // R8: an alarm interrupt implies the batch is really in the silo
    p_alarm_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.alarm && irq) |-> (int'(level) >= ALARM_LVL));
endmodule

// File: tb/test_silo_rx_top.sv
module test_silo_rx_top;
    localparam int NL = 8;
    localparam int DEPTH = 64;
    localparam int ALVL = 16;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0] rx_stb = '0;
    logic [NL*8-1:0] rx_char = '0;
    logic [NL-1:0] rx_ferr = '0;
    logic [NL-1:0] rx_perr = '0;
    logic ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic buf_rd = 1'b0;
    logic [15:0] buf_rdata;
    logic irq;

    always #10 clk = ~clk;

    silo_rx_top i_silo_rx_top (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_char(rx_char),
        .rx_ferr(rx_ferr), .rx_perr(rx_perr), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata), .irq(irq)
    );

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    // behavioural reference state
    logic [15:0] m_ctl;
    bit          m_hv [NL];
    logic [7:0]  m_hc [NL];
    bit          m_hf [NL], m_hp [NL], m_ho [NL], m_lost [NL];
    int          m_last;
    logic [15:0] m_q [$];
    int          m_acnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = '0; m_last = NL - 1; m_q.delete(); m_acnt = 0;
            for (int i = 0; i < NL; i++) begin
                m_hv[i] = 0; m_hc[i] = '0; m_hf[i] = 0; m_hp[i] = 0; m_ho[i] = 0; m_lost[i] = 0;
            end
        end else begin
            bit mse, push, pop;
            int pl;
            logic [15:0] w;
            mse = m_ctl[5];
            push = 0; pl = 0; w = '0;
            if (mse && m_q.size() < DEPTH)
                for (int k = 1; k <= NL; k++) begin
                    int c;
                    c = (m_last + k) % NL;
                    if (m_hv[c] && !push) begin push = 1; pl = c; end
                end
            if (push) w = {1'b1, m_ho[pl], m_hf[pl], m_hp[pl], 1'b0, 3'(pl), m_hc[pl]};
            pop = buf_rd && m_q.size() > 0;
            if (pop) void'(m_q.pop_front());
            if (push) m_q.push_back(w);
            if (pop) m_acnt = push ? 1 : 0;
            else if (push && m_acnt < ALVL) m_acnt++;
            for (int i = 0; i < NL; i++) begin
                bit g;
                g = push && pl == i;
                if (mse && rx_stb[i]) begin
                    if (m_hv[i] && !g) m_lost[i] = 1;
                    else begin
                        m_hv[i] = 1; m_hc[i] = rx_char[i*8 +: 8];
                        m_hf[i] = rx_ferr[i]; m_hp[i] = rx_perr[i];
                        m_ho[i] = m_lost[i]; m_lost[i] = 0;
                    end
                end else if (g) m_hv[i] = 0;
            end
            if (push) m_last = pl;
            if (ctl_wr) m_ctl = ctl_wdata;
        end
    end

    function automatic logic [15:0] m_word();
        return (m_q.size() > 0) ? m_q[0] : 16'h0000;
    endfunction

    function automatic bit m_irq();
        if (!m_ctl[6]) return 0;
        return m_ctl[12] ? (m_acnt >= ALVL) : (m_q.size() > 0);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison with the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R10 model word", buf_rdata, m_word());
            chk("R7/R8 model irq", {15'b0, irq}, {15'b0, m_irq()});
        end
    end

    task automatic report();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !finished) begin
            checks++; fails++;
            $display("FAIL R9 watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            report();
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(logic [15:0] v);
        ctl_wr = 1; ctl_wdata = v; cyc(1); ctl_wr = 0;
    endtask

    task automatic strobe(int ln, logic [7:0] ch, bit f, bit p);
        rx_stb[ln] = 1; rx_char[ln*8 +: 8] = ch; rx_ferr[ln] = f; rx_perr[ln] = p;
        cyc(1);
        rx_stb = '0; rx_ferr = '0; rx_perr = '0;
    endtask

    task automatic pop1();
        buf_rd = 1; cyc(1); buf_rd = 0;
    endtask

    initial begin
        int n;
        bit saw_drop;
        logic [15:0] lastw;
        cyc(3);
        chk("R11 reset word", buf_rdata, 16'h0000);
        chk("R11 reset irq", {15'b0, irq}, 16'h0000);
        rst_n = 1;
        cyc(1);

        // R1 R2 R7: one character with framing error on line 5
        wr_ctl(16'h0060);
        strobe(5, 8'hA5, 1, 0);
        cyc(1);
        chk("R1 R2 word line5", buf_rdata, 16'hA5A5);
        chk("R7 irq nonempty", {15'b0, irq}, 16'h0001);
        pop1();
        chk("R9 pop to empty", buf_rdata, 16'h0000);
        chk("R7 irq empty", {15'b0, irq}, 16'h0000);
        pop1();
        chk("R9 empty read", buf_rdata, 16'h0000);

        // R2 parity flag on line 2
        strobe(2, 8'h3C, 0, 1);
        cyc(1);
        chk("R2 parity word", buf_rdata, 16'h923C);
        pop1();

        // R6 R10: lines 1, 3, 6 together after line 2 was served
        rx_stb = 8'b0100_1010;
        rx_char[1*8 +: 8] = 8'h11; rx_char[3*8 +: 8] = 8'h33; rx_char[6*8 +: 8] = 8'h66;
        cyc(1);
        rx_stb = '0;
        cyc(4);
        chk("R6 first line3", buf_rdata, 16'h8333);
        pop1();
        chk("R6 second line6", buf_rdata, 16'h8666);
        pop1();
        chk("R6 wrap line1", buf_rdata, 16'h8111);
        pop1();

        // R5: scanning disabled
        wr_ctl(16'h0040);
        strobe(4, 8'h44, 0, 0);
        cyc(2);
        chk("R5 scan off word", buf_rdata, 16'h0000);
        wr_ctl(16'h0060);
        cyc(2);
        chk("R5 strobe ignored", buf_rdata, 16'h0000);

        // R8: alarm mode
        wr_ctl(16'h1060);
        for (int i = 0; i < 15; i++) begin
            rx_stb[0] = 1; rx_char[7:0] = 8'(i); cyc(1);
        end
        rx_stb = '0;
        cyc(1);
        chk("R8 fifteen no irq", {15'b0, irq}, 16'h0000);
        strobe(0, 8'h0F, 0, 0);
        cyc(1);
        chk("R8 sixteen irq", {15'b0, irq}, 16'h0001);
        pop1();
        chk("R8 read rearms", {15'b0, irq}, 16'h0000);
        chk("R10 order after read", buf_rdata, 16'h8001);

        // R3 R4: fill to the limit, then hold and drop on line 7
        for (int i = 0; i < 49; i++) begin
            rx_stb[0] = 1; rx_char[7:0] = 8'(8'h40 + i); cyc(1);
        end
        rx_stb = '0;
        cyc(2);
        strobe(7, 8'h5A, 0, 0);
        cyc(1);
        strobe(7, 8'h77, 0, 0);
        cyc(2);
        n = 0; saw_drop = 0; lastw = '0;
        while (buf_rdata[15] && n < 200) begin
            lastw = buf_rdata;
            if (buf_rdata == 16'h8777) saw_drop = 1;
            pop1();
            n++;
        end
        chk("R3 drained count", 16'(n), 16'd65);
        chk("R3 held char kept", lastw, 16'h875A);
        chk("R4 dropped absent", {15'b0, saw_drop}, 16'h0000);
        strobe(7, 8'h21, 0, 0);
        cyc(1);
        chk("R4 overrun flagged", buf_rdata, 16'hC721);
        pop1();
        strobe(7, 8'h22, 0, 0);
        cyc(1);
        chk("R4 overrun cleared", buf_rdata, 16'h8722);
        pop1();
        chk("R9 final empty", buf_rdata, 16'h0000);
        cyc(2);
        report();
    end
endmodule